// File: doc/BRIEF.md
# Serial GPIO Chain Controller

This block adds general-purpose pins to a chip by driving a daisy chain of external shift registers over four wires: a serial clock, a data-out line, a data-in line and a load strobe. Up to 32 ports are supported, and each port carries 1 to 4 bits. During a burst the controller shifts one output bit per serial clock period. On the same clock it samples one input bit from the chain. A single-cycle load strobe ends the burst, and the external registers then update all their outputs at once.

Software sets up the block through a small register interface. A control word holds the bits-per-port field, an auto-repeat enable and a self-clearing single-shot trigger. Further registers hold the serial clock divider and a 32-bit port-enable mask. Each port has its own configuration word that selects its output levels. Sampled inputs appear in one read-only word per bit index, with one bit per port. With auto-repeat on, a burst is followed by a fixed idle gap, and then the next burst starts.

Top module: `sgpio_chain`

## Requirements
- R1: After a synchronous reset, every register reads zero and ser_clk, ser_load and ser_dout are low.
- R2: A burst shifts every enabled port (mask at address 0x02) in ascending port order, and bits 0 up to W-1 within each port. W is one plus the 2-bit field in control bits [1:0]. Disabled ports are skipped.
- R3: The bit shifted for bit n of port p is bit 3*n of that port's 12-bit configuration word at address 0x20+p. A read returns all 12 stored bits, and written bits above bit 11 are dropped.
- R4: One serial bit lasts D system cycles, where D is the 12-bit divider at address 0x01 and values below 2 act as 2. ser_clk is low for the first floor(D/2) cycles of the bit and high for the rest.
- R5: Input word n at address 0x04+n holds, in bit p, the ser_din value sampled for bit n of port p in the last burst. Disabled ports and bit indices at or above W read zero.
- R6: The input words change only at the end of a burst, all together. A read in the middle of a burst returns the previous burst's values.
- R7: ser_load pulses high for exactly one system cycle after the last bit of every burst, while ser_clk is low. This includes a burst with an all-zero mask, which shifts no bits.
- R8: Writing 1 to control bit 3 (single-shot) starts one burst. When auto-repeat is off, the bit clears at the end of that burst and no further burst follows.
- R9: With control bit 2 (auto-repeat) set, bursts repeat. Consecutive ser_load pulses are N*D + GAP_CYCLES + 2 cycles apart, where N is the number of bits shifted, and a set single-shot bit is never cleared.
- R10: ser_din is sampled on the system clock edge that ends each serial bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the address |
| ser_clk | output | 1 | Serial shift clock to the chain |
| ser_dout | output | 1 | Serial output data to the chain |
| ser_din | input | 1 | Serial input data from the chain |
| ser_load | output | 1 | Load strobe, one cycle at the end of each burst |

## Verification
The bench builds the block with its full 32-port, 4-bit, 12-bit-divider geometry and shortens the burst gap to 20 cycles, so the exact spacing of auto-repeated load strobes can be measured in a short run. Divider settings of 0 and 1 reach the clamp to 2. An all-ones mask with four bits per port fills all 128 input bit positions. An all-zero mask gives an empty burst that still produces a strobe. A model of the external chain records ser_dout on each rising ser_clk and drives a known pattern on ser_din, so output order, bit-source stride and input transposition are all checked at the pins.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LOAD  = 2'd2,
    ST_GAP   = 2'd3
  } burst_st_e;

  // low-half register addresses
  localparam int A_CTRL = 0;
  localparam int A_DIV  = 1;
  localparam int A_EN   = 2;
  localparam int A_IN0  = 4;

  // control word bit positions
  localparam int C_AUTO = 2;
  localparam int C_SHOT = 3;

  // spacing of per-bit output sources inside a port word
  localparam int SRC_STRIDE = 3;

endpackage

// File: rtl/sgpio_next_port.sv
module sgpio_next_port #(
  parameter  int NUM_PORTS = 32,
  localparam int PW        = $clog2(NUM_PORTS)
) (
  input  logic [NUM_PORTS-1:0] mask,
  input  logic [PW:0]          start,
  output logic                 found,
  output logic [PW-1:0]        port
);

  // lowest enabled port at or above start
  always_comb begin
    found = 1'b0;
    port  = '0;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (mask[i] && ((PW+1)'(i) >= start)) begin
        found = 1'b1;
        port  = PW'(i);
      end
    end
  end

endmodule

// File: rtl/sgpio_regs.sv
module sgpio_regs
  import sgpio_pkg::*;
#(
  parameter  int NUM_PORTS = 32,
  parameter  int MAX_BITS  = 4,
  parameter  int DIV_W     = 12,
  localparam int PW        = $clog2(NUM_PORTS),
  localparam int WB        = $clog2(MAX_BITS),
  localparam int FW        = SRC_STRIDE * MAX_BITS,
  localparam int AW        = PW + 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_wr,
  input  logic [AW-1:0]                 reg_addr,
  input  logic [31:0]                   reg_wdata,
  output logic [31:0]                   reg_rdata,
  input  logic                          burst_done,
  input  logic [MAX_BITS*NUM_PORTS-1:0] in_flat,
  output logic [WB-1:0]                 width_m1,
  output logic                          auto_rep,
  output logic                          single_shot,
  output logic [DIV_W-1:0]              div,
  output logic [NUM_PORTS-1:0]          port_en,
  output logic [NUM_PORTS*FW-1:0]       cfg_flat
);

  localparam int LW = AW - 1;

  logic [FW-1:0] cfg_mem [NUM_PORTS];
  logic [31:0]   rd_next;
  logic          is_cfg;
  logic          ctrl_wr;
  logic          unused_wbits;

  assign is_cfg       = reg_addr[AW-1];
  assign ctrl_wr      = reg_wr && !is_cfg && (reg_addr[LW-1:0] == LW'(A_CTRL));
  assign unused_wbits = ^reg_wdata;

  genvar g;
  generate
    for (g = 0; g < NUM_PORTS; g++) begin : g_flat
      assign cfg_flat[g*FW +: FW] = cfg_mem[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      width_m1    <= '0;
      auto_rep    <= 1'b0;
      single_shot <= 1'b0;
      div         <= '0;
      port_en     <= '0;
      for (int i = 0; i < NUM_PORTS; i++) cfg_mem[i] <= '0;
    end else begin
      if (burst_done && !auto_rep) single_shot <= 1'b0;
      if (reg_wr) begin
        if (is_cfg) begin
          cfg_mem[reg_addr[PW-1:0]] <= reg_wdata[FW-1:0];
        end else if (ctrl_wr) begin
          width_m1    <= reg_wdata[WB-1:0];
          auto_rep    <= reg_wdata[C_AUTO];
          single_shot <= reg_wdata[C_SHOT];
        end else if (reg_addr[LW-1:0] == LW'(A_DIV)) begin
          div <= reg_wdata[DIV_W-1:0];
        end else if (reg_addr[LW-1:0] == LW'(A_EN)) begin
          port_en <= reg_wdata[NUM_PORTS-1:0];
        end
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (is_cfg) begin
      rd_next[FW-1:0] = cfg_mem[reg_addr[PW-1:0]];
    end else if (reg_addr[LW-1:0] == LW'(A_CTRL)) begin
      rd_next[WB-1:0] = width_m1;
      rd_next[C_AUTO] = auto_rep;
      rd_next[C_SHOT] = single_shot;
    end else if (reg_addr[LW-1:0] == LW'(A_DIV)) begin
      rd_next[DIV_W-1:0] = div;
    end else if (reg_addr[LW-1:0] == LW'(A_EN)) begin
      rd_next[NUM_PORTS-1:0] = port_en;
    end else begin
      for (int b = 0; b < MAX_BITS; b++) begin
        if (reg_addr[LW-1:0] == LW'(A_IN0 + b))
          rd_next[NUM_PORTS-1:0] = in_flat[b*NUM_PORTS +: NUM_PORTS];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

endmodule

// File: rtl/sgpio_shifter.sv
module sgpio_shifter
  import sgpio_pkg::*;
#(
  parameter  int NUM_PORTS  = 32,
  parameter  int MAX_BITS   = 4,
  parameter  int DIV_W      = 12,
  parameter  int GAP_CYCLES = 1024,
  localparam int PW         = $clog2(NUM_PORTS),
  localparam int WB         = $clog2(MAX_BITS),
  localparam int FW         = SRC_STRIDE * MAX_BITS,
  localparam int GW         = $clog2(GAP_CYCLES + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          auto_rep,
  input  logic                          single_shot,
  input  logic [WB-1:0]                 width_m1,
  input  logic [DIV_W-1:0]              div,
  input  logic [NUM_PORTS-1:0]          port_en,
  input  logic [NUM_PORTS*FW-1:0]       cfg_flat,
  input  logic                          ser_din,
  output logic                          ser_clk,
  output logic                          ser_dout,
  output logic                          ser_load,
  output logic                          burst_done,
  output logic [MAX_BITS*NUM_PORTS-1:0] in_flat
);

  burst_st_e             state;
  logic [PW-1:0]         pidx;
  logic [WB-1:0]         bidx;
  logic [WB-1:0]         wq;
  logic [DIV_W-1:0]      cnt;
  logic [DIV_W-1:0]      dq;
  logic [DIV_W-1:0]      d_eff;
  logic [NUM_PORTS-1:0]  enq;
  logic [GW-1:0]         gap_cnt;
  logic [NUM_PORTS-1:0]  shadow [MAX_BITS];
  logic [NUM_PORTS-1:0]  in_q   [MAX_BITS];
  logic [FW-1:0]         cur_cfg;
  logic                  bit_end;
  logic [NUM_PORTS-1:0]  scan_mask;
  logic [PW:0]           scan_start;
  logic                  nxt_found;
  logic [PW-1:0]         nxt_port;

  assign d_eff      = (div < DIV_W'(2)) ? DIV_W'(2) : div;
  assign bit_end    = (cnt == dq - DIV_W'(1));
  assign cur_cfg    = cfg_flat[int'(pidx)*FW +: FW];
  assign scan_mask  = (state == ST_IDLE) ? port_en : enq;
  assign scan_start = (state == ST_IDLE) ? '0 : ({1'b0, pidx} + (PW+1)'(1));

  sgpio_next_port #(.NUM_PORTS(NUM_PORTS)) u_scan (
    .mask  (scan_mask),
    .start (scan_start),
    .found (nxt_found),
    .port  (nxt_port)
  );

  assign ser_clk    = (state == ST_SHIFT) && (cnt >= (dq >> 1));
  assign ser_dout   = (state == ST_SHIFT) && cur_cfg[SRC_STRIDE*int'(bidx)];
  assign ser_load   = (state == ST_LOAD);
  assign burst_done = (state == ST_LOAD);

  genvar g;
  generate
    for (g = 0; g < MAX_BITS; g++) begin : g_in
      assign in_flat[g*NUM_PORTS +: NUM_PORTS] = in_q[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      pidx    <= '0;
      bidx    <= '0;
      wq      <= '0;
      cnt     <= '0;
      dq      <= DIV_W'(2);
      enq     <= '0;
      gap_cnt <= '0;
      for (int b = 0; b < MAX_BITS; b++) begin
        shadow[b] <= '0;
        in_q[b]   <= '0;
      end
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (auto_rep || single_shot) begin
            wq   <= width_m1;
            enq  <= port_en;
            dq   <= d_eff;
            cnt  <= '0;
            bidx <= '0;
            for (int b = 0; b < MAX_BITS; b++) shadow[b] <= '0;
            if (nxt_found) begin
              pidx  <= nxt_port;
              state <= ST_SHIFT;
            end else begin
              state <= ST_LOAD;
            end
          end
        end
        ST_SHIFT: begin
          if (bit_end) begin
            cnt                <= '0;
            shadow[bidx][pidx] <= ser_din;
            if (bidx == wq) begin
              bidx <= '0;
              if (nxt_found) pidx  <= nxt_port;
              else           state <= ST_LOAD;
            end else begin
              bidx <= bidx + WB'(1);
            end
          end else begin
            cnt <= cnt + DIV_W'(1);
          end
        end
        ST_LOAD: begin
          for (int b = 0; b < MAX_BITS; b++) in_q[b] <= shadow[b];
          gap_cnt <= '0;
          state   <= auto_rep ? ST_GAP : ST_IDLE;
        end
        ST_GAP: begin
          if (gap_cnt == GW'(GAP_CYCLES - 1)) state   <= ST_IDLE;
          else                                gap_cnt <= gap_cnt + GW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sgpio_chain.sv
module sgpio_chain
  import sgpio_pkg::*;
#(
  parameter  int NUM_PORTS  = 32,
  parameter  int MAX_BITS   = 4,
  parameter  int DIV_W      = 12,
  parameter  int GAP_CYCLES = 1024,
  localparam int PW         = $clog2(NUM_PORTS),
  localparam int WB         = $clog2(MAX_BITS),
  localparam int FW         = SRC_STRIDE * MAX_BITS,
  localparam int AW         = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          ser_clk,
  output logic          ser_dout,
  input  logic          ser_din,
  output logic          ser_load
);

  logic                          burst_done;
  logic [MAX_BITS*NUM_PORTS-1:0] in_flat;
  logic [WB-1:0]                 width_m1;
  logic                          auto_rep;
  logic                          single_shot;
  logic [DIV_W-1:0]              div;
  logic [NUM_PORTS-1:0]          port_en;
  logic [NUM_PORTS*FW-1:0]       cfg_flat;

  sgpio_regs #(
    .NUM_PORTS (NUM_PORTS),
    .MAX_BITS  (MAX_BITS),
    .DIV_W     (DIV_W)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .burst_done  (burst_done),
    .in_flat     (in_flat),
    .width_m1    (width_m1),
    .auto_rep    (auto_rep),
    .single_shot (single_shot),
    .div         (div),
    .port_en     (port_en),
    .cfg_flat    (cfg_flat)
  );

  sgpio_shifter #(
    .NUM_PORTS  (NUM_PORTS),
    .MAX_BITS   (MAX_BITS),
    .DIV_W      (DIV_W),
    .GAP_CYCLES (GAP_CYCLES)
  ) u_shift (
    .clk         (clk),
    .rst         (rst),
    .auto_rep    (auto_rep),
    .single_shot (single_shot),
    .width_m1    (width_m1),
    .div         (div),
    .port_en     (port_en),
    .cfg_flat    (cfg_flat),
    .ser_din     (ser_din),
    .ser_clk     (ser_clk),
    .ser_dout    (ser_dout),
    .ser_load    (ser_load),
    .burst_done  (burst_done),
    .in_flat     (in_flat)
  );

endmodule

// File: rtl/sgpio_chain_chk.sv
module sgpio_chain_chk #(
  parameter int NUM_PORTS = 32,
  parameter int MAX_BITS  = 4,
  parameter int AW        = 6
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          reg_wr,
  input logic [AW-1:0]                 reg_addr,
  input logic                          ser_load,
  input logic                          ser_clk,
  input logic                          burst_done,
  input logic                          auto_rep,
  input logic                          single_shot,
  input logic [MAX_BITS*NUM_PORTS-1:0] in_flat
);

  logic ctrl_wr;
  assign ctrl_wr = reg_wr && (reg_addr == '0);

  p_load_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    ser_load |=> !ser_load);

  p_load_clk_low_r7: assert property (@(posedge clk) disable iff (rst)
    ser_load |-> !ser_clk);

  p_shot_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (burst_done && !auto_rep && !ctrl_wr) |=> !single_shot);

  p_shot_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (burst_done && auto_rep && single_shot && !ctrl_wr) |=> single_shot);

  p_in_atomic_r6: assert property (@(posedge clk) disable iff (rst)
    !burst_done |=> $stable(in_flat));

endmodule

bind sgpio_chain sgpio_chain_chk #(
  .NUM_PORTS (NUM_PORTS),
  .MAX_BITS  (MAX_BITS),
  .AW        (AW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .ser_load    (ser_load),
  .ser_clk     (ser_clk),
  .burst_done  (burst_done),
  .auto_rep    (auto_rep),
  .single_shot (single_shot),
  .in_flat     (in_flat)
);

// File: tb/sim_sgpio_chain.sv
`timescale 1ns/1ps
module sim_sgpio_chain;

  localparam int GAP = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ser_clk, ser_dout, ser_load;
  logic        ser_din = 1'b0;

  always #4 clk = ~clk;

  sgpio_chain #(.GAP_CYCLES(GAP)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ser_clk(ser_clk),
    .ser_dout(ser_dout), .ser_din(ser_din), .ser_load(ser_load)
  );

  int n_chk = 0;
  int n_bad = 0;

  // chain model state
  int           cyc = 0;
  int           idx = 0;
  int           out_n = 0;
  int           snap_n = 0;
  int           loads = 0;
  int           load_t = 0;
  int           load_tp = 0;
  int           rise_t [128];
  int           snap_t0 = 0;
  int           snap_t1 = 0;
  logic         prev_clk = 1'b0;
  logic [127:0] out_log = '0;
  logic [127:0] snap_log = '0;
  logic [127:0] in_seed = '0;

  // expectations
  logic [31:0]  cfg_m [32];
  logic [127:0] exp_out;
  int           exp_n;
  logic [31:0]  exp_in [4];

  // {width_m1, divider, port mask, seed}
  localparam logic [77:0] VEC [6] = '{
    {2'd0, 12'd2, 32'h0000_0001, 32'h1234_5678},
    {2'd3, 12'd3, 32'h8000_0001, 32'h9ABC_DEF0},
    {2'd1, 12'd5, 32'h0F0F_00F0, 32'h0BAD_F00D},
    {2'd2, 12'd0, 32'hFFFF_FFFF, 32'hCAFE_1234},
    {2'd3, 12'd2, 32'hFFFF_FFFF, 32'h5EED_0042},
    {2'd0, 12'd1, 32'h0000_0000, 32'h7777_AAAA}
  };

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      idx = 0; out_n = 0; prev_clk = 1'b0;
    end else begin
      if (ser_clk && !prev_clk && out_n < 128) begin
        out_log[out_n] = ser_dout;
        rise_t[out_n]  = cyc;
        out_n++;
      end
      if (ser_load) begin
        snap_n   = out_n;
        snap_log = out_log;
        snap_t0  = rise_t[0];
        snap_t1  = rise_t[1];
        out_n    = 0;
        idx      = 0;
        load_tp  = load_t;
        load_t   = cyc;
        loads++;
      end else if (!ser_clk && prev_clk) begin
        idx++;
      end
      prev_clk = ser_clk;
    end
    ser_din = (idx < 128) ? in_seed[idx] : 1'b0;
  end

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_load(input int l0, input string req);
    int k = 0;
    while (loads == l0 && k < 5000) begin
      @(negedge clk);
      k++;
    end
    chk(req, "load strobe seen", 128'(loads > l0), 128'(1));
  endtask

  function automatic logic [31:0] cfg_val(input logic [31:0] sd, input int p);
    logic [31:0] t;
    t = (sd >> (p % 16)) ^ (32'(p) * 32'h2C5);
    return {20'b0, t[11:0]};
  endfunction

  function automatic logic [127:0] mk_seed(input logic [31:0] sd);
    return {sd, ~sd, sd ^ 32'hA5C3_5A3C, sd[15:0], sd[31:16]};
  endfunction

  task automatic compute(input logic [1:0] w, input logic [31:0] en);
    int k = 0;
    exp_out = '0;
    for (int b = 0; b < 4; b++) exp_in[b] = '0;
    for (int p = 0; p < 32; p++) begin
      if (en[p]) begin
        for (int b = 0; b <= int'(w); b++) begin
          exp_out[k]  = cfg_m[p][3*b];
          exp_in[b][p] = in_seed[k];
          k++;
        end
      end
    end
    exp_n = k;
  endtask

  task automatic check_words(input string req);
    logic [31:0] d;
    for (int b = 0; b < 4; b++) begin
      rd(6'(4 + b), d);
      chk(req, $sformatf("input word %0d", b), 128'(d), 128'(exp_in[b]));
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [1:0]  w;
    logic [11:0] dv;
    logic [31:0] en, sd;
    logic [127:0] m;
    int l0, l1, deff;

    for (int p = 0; p < 32; p++) cfg_m[p] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1", "ser_clk", 128'(ser_clk), 128'(0));
    chk("R1", "ser_load", 128'(ser_load), 128'(0));
    chk("R1", "ser_dout", 128'(ser_dout), 128'(0));
    rd(6'h00, d); chk("R1", "ctrl", 128'(d), 128'(0));
    rd(6'h01, d); chk("R1", "divider", 128'(d), 128'(0));
    rd(6'h02, d); chk("R1", "mask", 128'(d), 128'(0));
    rd(6'h20, d); chk("R1", "cfg port0", 128'(d), 128'(0));
    rd(6'h3F, d); chk("R1", "cfg port31", 128'(d), 128'(0));
    rd(6'h04, d); chk("R1", "input word0", 128'(d), 128'(0));

    // table walk: R2 R3 R4 R5 R7 R8 R10
    for (int i = 0; i < 6; i++) begin
      {w, dv, en, sd} = VEC[i];
      in_seed = mk_seed(sd);
      for (int p = 0; p < 32; p++) begin
        cfg_m[p] = cfg_val(sd, p);
        wr(6'(32 + p), cfg_m[p]);
      end
      wr(6'h01, {20'b0, dv});
      wr(6'h02, en);
      l0 = loads;
      wr(6'h00, {28'b0, 1'b1, 1'b0, w});
      wait_load(l0, "R7");
      compute(w, en);
      chk("R2", $sformatf("vec%0d bit count", i), 128'(snap_n), 128'(exp_n));
      m = (exp_n >= 128) ? '1 : ((128'(1) << exp_n) - 128'(1));
      chk("R3", $sformatf("vec%0d dout stream", i), snap_log & m, exp_out);
      deff = (dv < 2) ? 2 : int'(dv);
      if (exp_n >= 2)
        chk("R4", $sformatf("vec%0d sclk period", i),
            128'(snap_t1 - snap_t0), 128'(deff));
      check_words("R5 R10");
      rd(6'h00, d);
      chk("R8", $sformatf("vec%0d shot cleared", i), 128'(d), 128'({30'b0, w}));
    end

    // R3: readback keeps 12 bits, drops upper bits
    wr(6'h3F, 32'h0000_0FFF); cfg_m[31] = 32'h0000_0FFF;
    rd(6'h3F, d); chk("R3", "cfg readback all ones", 128'(d), 128'(32'hFFF));
    wr(6'h27, 32'h000A_BCDE); cfg_m[7] = 32'h0000_0CDE;
    rd(6'h27, d); chk("R3", "cfg upper bits dropped", 128'(d), 128'(32'hCDE));

    // R6: atomic input update
    in_seed = mk_seed(32'h1357_9BDF);
    wr(6'h01, 32'd4);
    wr(6'h02, 32'hFFFF_FFFF);
    l0 = loads;
    wr(6'h00, 32'h0000_000B);
    wait_load(l0, "R6");
    compute(2'd3, 32'hFFFF_FFFF);
    check_words("R6");
    d = exp_in[1];
    in_seed = mk_seed(32'h2468_ACE0);
    l0 = loads;
    wr(6'h00, 32'h0000_000B);
    repeat (150) @(negedge clk);
    begin
      logic [31:0] mid;
      rd(6'h05, mid);
      chk("R6", "mid-burst word1 unchanged", 128'(mid), 128'(d));
    end
    wait_load(l0, "R6");
    compute(2'd3, 32'hFFFF_FFFF);
    check_words("R6");

    // R9: auto-repeat spacing, single-shot held
    wr(6'h01, 32'd2);
    wr(6'h02, 32'h0000_0005);
    l0 = loads;
    wr(6'h00, 32'h0000_000C);
    wait_load(l0, "R9");
    wait_load(l0 + 1, "R9");
    wait_load(l0 + 2, "R9");
    chk("R9", "load spacing", 128'(load_t - load_tp), 128'(2 * 2 + GAP + 2));
    rd(6'h00, d); chk("R9", "shot bit held", 128'(d), 128'(32'hC));

    // R8: auto off, pending shot finishes then stops
    wr(6'h00, 32'h0000_0008);
    repeat (300) @(negedge clk);
    rd(6'h00, d); chk("R8", "shot cleared after auto off", 128'(d), 128'(0));
    l1 = loads;
    repeat (200) @(negedge clk);
    chk("R8", "no further bursts", 128'(loads), 128'(l1));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule